// File: doc/BRIEF.md
# Eight-Pin GPIO Controller with Interrupts

This block is an eight-pin general purpose I/O peripheral on a simple memory-mapped register bus. Each pin has a direction bit and an output data bit. The pad output-enable follows the direction bit. Input pins go through a two-flop synchroniser before any logic sees them. The data register is reached through address-bit masking. Byte-address bits [9:2] of a data-region access form a per-pin mask, so software can update or sample any subset of pins in one access, with no read-modify-write.

Each input pin can raise an interrupt. Per pin, it can be set to detect a level, to detect both edges, or to detect one edge of a chosen polarity. Detections collect in a sticky raw status register. Software clears status bits by writing ones to a clear register. Raw status is qualified by an enable mask. The combined interrupt output is high whenever any enabled status bit is set. A block of read-only identification words sits at the top of the address space.

Bus writes take effect at the rising clock edge where select and write are both high. Read data is combinational from the address while select is high and write is low.

Top module: `gpio_irq_ctrl`

## Requirements
- R1: After reset, all of these are zero: every register, `pinOut`, `pinOe`, `irqOut`, and every status read.
- R2: The configuration registers keep only the low 8 bits of a write and read back zero-extended. Their byte offsets are: direction 0x400, sense 0x404, both-edges 0x408, polarity 0x40C, enable 0x410, mode 0x420. `pinOe` equals the direction register, where 1 means output.
- R3: A write to any offset below 0x400 changes an output-data bit only where `paddr[9:2]` has a 1 and the pin is an output. `pinOut` shows the output-data register.
- R4: A read below 0x400 returns the pin values ANDed with `paddr[9:2]`. A pin's value is its output-data bit when the pin is an output. When the pin is an input, its value is the synchronised input.
- R5: With sense=0 and both-edges=1, any change on an input pin sets its raw status bit, at the latest 3 clock edges after the change.
- R6: With sense=0 and both-edges=0, polarity=1 catches only rising edges and polarity=0 catches only falling edges.
- R7: A pin whose direction bit is 1 never sets its raw status bit through edge detection.
- R8: With sense=1, the raw status bit is set while the pin value equals the polarity bit. If the bit is cleared while that level is still present, it sets again.
- R9: Writing to 0x41C clears every raw status bit written as 1. Other bits are unchanged. The clear wins over a detection in the same cycle.
- R10: Raw status reads at 0x414. Masked status reads at 0x418 and equals raw AND enable. `irqOut` is 1 exactly when masked status is nonzero.
- R11: Reads at 0xFE0 + 4*k, for k = 0..7, return the bytes 0x61, 0x10, 0x14, 0x00, 0x0D, 0xF0, 0x05, 0xB1 in that order of k. Writes there are ignored.
- R12: Reads of unmapped offsets, of unaligned offsets, and of 0x41C return zero. Writes to unmapped offsets and to the two status offsets change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| psel | input | 1 | Bus select |
| pwrite | input | 1 | Write enable (1 = write) |
| paddr | input | 12 | Byte address |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data, combinational |
| pinIn | input | 8 | Pad input levels, asynchronous |
| pinOut | output | 8 | Pad output data |
| pinOe | output | 8 | Pad output enables |
| irqOut | output | 1 | Combined interrupt |

## Verification
The bench drives random sequences that mix five kinds of operation: configuration writes, masked data writes, pin toggles, status clears, and writes to unmapped or read-only offsets. After every operation it compares status, pad signals, a masked data read and a configuration read-back against a bench model. Pin toggles under random sense, both-edges and polarity settings separate edge mode from level mode and rising from falling. Toggles on pins set as outputs show that edge detection is gated by direction. Random masks on data accesses show whether address bits or direction are ignored. Directed cases cover the reset state, the identification words, unmapped reads, writes to read-only offsets, and a level interrupt that comes back after a clear.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  localparam int NUM_PINS = 8;

  typedef enum logic [3:0] {
    RD_NONE, RD_DATA, RD_DIR, RD_SENSE, RD_BOTH, RD_EVENT,
    RD_ENABLE, RD_RAW, RD_MASKED, RD_MODE, RD_ID
  } rdSel_e;

  typedef struct packed {
    logic wrData;
    logic wrDir;
    logic wrSense;
    logic wrBoth;
    logic wrEvent;
    logic wrEnable;
    logic wrClear;
    logic wrMode;
    rdSel_e rdSel;
    logic [2:0] idIdx;
    logic [NUM_PINS-1:0] bitMask;
  } gpioStrb_t;

  function automatic logic [7:0] idByte(input logic [2:0] k);
    case (k)
      3'd0: idByte = 8'h61;
      3'd1: idByte = 8'h10;
      3'd2: idByte = 8'h14;
      3'd3: idByte = 8'h00;
      3'd4: idByte = 8'h0D;
      3'd5: idByte = 8'hF0;
      3'd6: idByte = 8'h05;
      default: idByte = 8'hB1;
    endcase
  endfunction
endpackage

// File: rtl/gpio_ctrl.sv
module gpio_ctrl
  import gpio_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              psel,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  output gpioStrb_t         strb
);
  localparam int WORD_W = ADDR_W - 2;

  logic [WORD_W-1:0] wordAddr;
  logic aligned, inData, inId, doWr, doRd;

  assign wordAddr = paddr[ADDR_W-1:2];
  assign aligned  = (paddr[1:0] == 2'b00);
  assign inData   = aligned && (paddr[ADDR_W-1:ADDR_W-2] == 2'b00);
  assign inId     = aligned && (paddr[ADDR_W-1:5] == '1);
  assign doWr     = psel && pwrite;
  assign doRd     = psel && !pwrite;

  always_comb begin
    strb = '0;
    strb.rdSel = RD_NONE;
    strb.idIdx = paddr[4:2];
    strb.bitMask = paddr[NUM_PINS+1:2];
    if (inData) begin
      strb.wrData = doWr;
      if (doRd) strb.rdSel = RD_DATA;
    end else if (inId) begin
      if (doRd) strb.rdSel = RD_ID;
    end else if (aligned) begin
      case (wordAddr)
        WORD_W'(12'h400 >> 2): begin strb.wrDir = doWr;    if (doRd) strb.rdSel = RD_DIR;    end
        WORD_W'(12'h404 >> 2): begin strb.wrSense = doWr;  if (doRd) strb.rdSel = RD_SENSE;  end
        WORD_W'(12'h408 >> 2): begin strb.wrBoth = doWr;   if (doRd) strb.rdSel = RD_BOTH;   end
        WORD_W'(12'h40C >> 2): begin strb.wrEvent = doWr;  if (doRd) strb.rdSel = RD_EVENT;  end
        WORD_W'(12'h410 >> 2): begin strb.wrEnable = doWr; if (doRd) strb.rdSel = RD_ENABLE; end
        WORD_W'(12'h414 >> 2): begin if (doRd) strb.rdSel = RD_RAW; end
        WORD_W'(12'h418 >> 2): begin if (doRd) strb.rdSel = RD_MASKED; end
        WORD_W'(12'h41C >> 2): strb.wrClear = doWr;
        WORD_W'(12'h420 >> 2): begin strb.wrMode = doWr;   if (doRd) strb.rdSel = RD_MODE;   end
        default: ;
      endcase
    end
  end

  // R12
  one_write_strobe_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.wrData, strb.wrDir, strb.wrSense, strb.wrBoth,
              strb.wrEvent, strb.wrEnable, strb.wrClear, strb.wrMode}));
endmodule

// File: rtl/gpio_dpath.sv
module gpio_dpath
  import gpio_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic                clk,
  input  logic                rstN,
  input  gpioStrb_t           strb,
  input  logic [DATA_W-1:0]   wdata,
  output logic [DATA_W-1:0]   rdata,
  input  logic [NUM_PINS-1:0] pinIn,
  output logic [NUM_PINS-1:0] pinOut,
  output logic [NUM_PINS-1:0] pinOe,
  output logic                irqOut
);
  localparam int N = NUM_PINS;

  logic [N-1:0] dirR, senseR, bothR, eventR, enableR, modeR, dataR, rawR;
  logic [N-1:0] syncA, syncB, prevB;
  logic [N-1:0] pinVal, edgeHit, lvlHit, clrMask, wByte, maskedSt;

  assign wByte = wdata[N-1:0];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      dirR <= '0; senseR <= '0; bothR <= '0; eventR <= '0;
      enableR <= '0; modeR <= '0; dataR <= '0;
      syncA <= '0; syncB <= '0; prevB <= '0;
    end else begin
      syncA <= pinIn;
      syncB <= syncA;
      prevB <= syncB;
      if (strb.wrDir)    dirR    <= wByte;
      if (strb.wrSense)  senseR  <= wByte;
      if (strb.wrBoth)   bothR   <= wByte;
      if (strb.wrEvent)  eventR  <= wByte;
      if (strb.wrEnable) enableR <= wByte;
      if (strb.wrMode)   modeR   <= wByte;
      if (strb.wrData) begin
        dataR <= (dataR & ~(strb.bitMask & dirR)) | (wByte & strb.bitMask & dirR);
      end
    end
  end

  assign pinVal = (dataR & dirR) | (syncB & ~dirR);

  for (genvar i = 0; i < N; i++) begin : g_pin
    logic rise, fall;
    assign rise = syncB[i] & ~prevB[i];
    assign fall = ~syncB[i] & prevB[i];
    assign edgeHit[i] = ~dirR[i] & ~senseR[i] &
                        (bothR[i] ? (rise | fall) : (eventR[i] ? rise : fall));
    assign lvlHit[i] = senseR[i] & (pinVal[i] == eventR[i]);
  end

  assign clrMask = strb.wrClear ? wByte : '0;

  always_ff @(posedge clk) begin
    if (!rstN) rawR <= '0;
    else       rawR <= (rawR | edgeHit | lvlHit) & ~clrMask;
  end

  assign maskedSt = rawR & enableR;
  assign irqOut   = |maskedSt;
  assign pinOut   = dataR;
  assign pinOe    = dirR;

  always_comb begin
    rdata = '0;
    case (strb.rdSel)
      RD_DATA:   rdata[N-1:0] = pinVal & strb.bitMask;
      RD_DIR:    rdata[N-1:0] = dirR;
      RD_SENSE:  rdata[N-1:0] = senseR;
      RD_BOTH:   rdata[N-1:0] = bothR;
      RD_EVENT:  rdata[N-1:0] = eventR;
      RD_ENABLE: rdata[N-1:0] = enableR;
      RD_RAW:    rdata[N-1:0] = rawR;
      RD_MASKED: rdata[N-1:0] = maskedSt;
      RD_MODE:   rdata[N-1:0] = modeR;
      RD_ID:     rdata[7:0]   = idByte(strb.idIdx);
      default:   rdata = '0;
    endcase
  end

  // R3
  data_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strb.wrData |=> $stable(dataR));
  // R2
  dir_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strb.wrDir |=> $stable(pinOe));
  // R9
  clear_wins_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.wrClear |=> ((rawR & $past(wByte)) == '0));
  // R7
  no_output_edge_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((rawR & ~$past(rawR) & $past(dirR) & ~$past(senseR)) == '0));
  // R8
  level_sets_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((rawR & $past(lvlHit & ~clrMask)) == $past(lvlHit & ~clrMask)));
endmodule

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl
  import gpio_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                psel,
  input  logic                pwrite,
  input  logic [ADDR_W-1:0]   paddr,
  input  logic [DATA_W-1:0]   pwdata,
  output logic [DATA_W-1:0]   prdata,
  input  logic [NUM_PINS-1:0] pinIn,
  output logic [NUM_PINS-1:0] pinOut,
  output logic [NUM_PINS-1:0] pinOe,
  output logic                irqOut
);
  gpioStrb_t strb;

  gpio_ctrl #(.ADDR_W(ADDR_W)) i_ctrl (
    .clk(clk), .rstN(rstN), .psel(psel), .pwrite(pwrite),
    .paddr(paddr), .strb(strb)
  );

  gpio_dpath #(.DATA_W(DATA_W)) i_dpath (
    .clk(clk), .rstN(rstN), .strb(strb), .wdata(pwdata), .rdata(prdata),
    .pinIn(pinIn), .pinOut(pinOut), .pinOe(pinOe), .irqOut(irqOut)
  );
endmodule

// File: tb/test_gpio_irq_ctrl.sv
module test_gpio_irq_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int STEPS = 400;

  logic clk = 0, rstN = 0, psel = 0, pwrite = 0;
  logic [11:0] paddr = '0;
  logic [31:0] pwdata = '0, prdata;
  logic [7:0] pinIn = '0, pinOut, pinOe;
  logic irqOut;

  int nChecks = 0, nFails = 0;
  bit finished = 0;

  // bench model
  logic [7:0] mDir, mSense, mBoth, mEvent, mEnable, mMode, mData, mRaw, mPin;

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_irq_ctrl i_gpio_irq_ctrl (
    .clk(clk), .rstN(rstN), .psel(psel), .pwrite(pwrite), .paddr(paddr),
    .pwdata(pwdata), .prdata(prdata), .pinIn(pinIn), .pinOut(pinOut),
    .pinOe(pinOe), .irqOut(irqOut)
  );

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    nChecks++;
    if (got !== exp) begin
      nFails++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic busWrite(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    psel = 1; pwrite = 1; paddr = a; pwdata = d;
    @(negedge clk);
    psel = 0; pwrite = 0;
  endtask

  task automatic busRead(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    psel = 1; pwrite = 0; paddr = a;
    #1 d = prdata;
    psel = 0;
  endtask

  task automatic settle();
    repeat (4) @(posedge clk);
  endtask

  function automatic logic [7:0] pinValue();
    return (mData & mDir) | (mPin & ~mDir);
  endfunction

  function automatic logic [7:0] levelSet();
    return mSense & ~(pinValue() ^ mEvent);
  endfunction

  function automatic logic [7:0] edgeSet(input logic [7:0] oldP, input logic [7:0] newP);
    logic [7:0] ch = (oldP ^ newP) & ~mDir & ~mSense;
    return ch & (mBoth | ~(newP ^ mEvent));
  endfunction

  function automatic logic [11:0] cfgAddr(input int k);
    case (k)
      0: return 12'h400; 1: return 12'h404; 2: return 12'h408;
      3: return 12'h40C; 4: return 12'h410; default: return 12'h420;
    endcase
  endfunction

  function automatic logic [7:0] cfgVal(input int k);
    case (k)
      0: return mDir; 1: return mSense; 2: return mBoth;
      3: return mEvent; 4: return mEnable; default: return mMode;
    endcase
  endfunction

  function automatic logic [7:0] idExp(input int k);
    case (k)
      0: return 8'h61; 1: return 8'h10; 2: return 8'h14; 3: return 8'h00;
      4: return 8'h0D; 5: return 8'hF0; 6: return 8'h05; default: return 8'hB1;
    endcase
  endfunction

  task automatic checkAll(input string tag);
    logic [31:0] r;
    logic [7:0] m;
    int k;
    busRead(12'h414, r); check({tag, " R10 raw"}, r, {24'h0, mRaw});
    busRead(12'h418, r); check({tag, " R10 masked"}, r, {24'h0, mRaw & mEnable});
    check({tag, " R10 irq"}, {31'h0, irqOut}, {31'h0, |(mRaw & mEnable)});
    check({tag, " R3 pinOut"}, {24'h0, pinOut}, {24'h0, mData});
    check({tag, " R2 pinOe"}, {24'h0, pinOe}, {24'h0, mDir});
    m = 8'($urandom);
    busRead({2'b00, m, 2'b00}, r); check({tag, " R4 data read"}, r, {24'h0, pinValue() & m});
    k = $urandom_range(0, 5);
    busRead(cfgAddr(k), r); check({tag, " R2 cfg read"}, r, {24'h0, cfgVal(k)});
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      nFails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    void'($urandom(32'd1234));
    {mDir, mSense, mBoth, mEvent, mEnable, mMode, mData, mRaw, mPin} = '0;
    repeat (3) @(posedge clk);
    @(negedge clk); rstN = 1;

    // R1 reset state
    for (int k = 0; k < 6; k++) begin
      busRead(cfgAddr(k), r); check("R1 cfg zero", r, 32'h0);
    end
    check("R1 pinOut", {24'h0, pinOut}, 32'h0);
    check("R1 pinOe", {24'h0, pinOe}, 32'h0);
    check("R1 irq", {31'h0, irqOut}, 32'h0);
    busRead(12'h414, r); check("R1 raw", r, 32'h0);

    // R11 identification words, writes ignored
    busWrite(12'hFE0, 32'hFF);
    for (int k = 0; k < 8; k++) begin
      busRead(12'hFE0 + 12'(4*k), r); check("R11 id", r, {24'h0, idExp(k)});
    end

    // R12 unmapped and unaligned reads, writes to status offsets ignored
    busRead(12'h424, r); check("R12 unmapped", r, 32'h0);
    busRead(12'h800, r); check("R12 reserved", r, 32'h0);
    busRead(12'h401, r); check("R12 unaligned", r, 32'h0);
    busRead(12'h41C, r); check("R12 clear read", r, 32'h0);
    busWrite(12'h414, 32'hFF);
    busWrite(12'h418, 32'hFF);
    busWrite(12'h424, 32'hFF);
    busWrite(12'h401, 32'hFF);
    settle();
    checkAll("R12");

    // R8 level re-asserts after clear; upper bits of config writes dropped (R2)
    busWrite(12'h410, 32'hFFFF_FF01); mEnable = 8'h01;
    busWrite(12'h404, 32'h0000_0001); mSense = 8'h01;
    settle(); mRaw |= levelSet();
    busRead(12'h414, r); check("R8 level low active", r, 32'h1);
    busWrite(12'h41C, 32'h1);
    settle();
    busRead(12'h414, r); check("R8 level reasserts", r, 32'h1);
    busRead(12'h410, r); check("R2 low byte only", r, 32'h1);

    // R9 clear one bit of several edge-captured ones
    busWrite(12'h404, 32'h0); mSense = 8'h0;
    busWrite(12'h408, 32'h0F); mBoth = 8'h0F;
    busWrite(12'h41C, 32'hFF); mRaw = 8'h0;
    @(negedge clk); pinIn = 8'h0F;
    settle(); mRaw |= edgeSet(mPin, 8'h0F); mPin = 8'h0F;
    busWrite(12'h41C, 32'h04); mRaw &= ~8'h04;
    settle();
    checkAll("R5 R9 directed");

    // random mix
    for (int s = 0; s < STEPS; s++) begin
      int op = $urandom_range(0, 5);
      logic [7:0] v = 8'($urandom);
      case (op)
        0, 1: begin
          int k = $urandom_range(0, 5);
          busWrite(cfgAddr(k), {24'($urandom), v});
          case (k)
            0: mDir = v; 1: mSense = v; 2: mBoth = v;
            3: mEvent = v; 4: mEnable = v; default: mMode = v;
          endcase
        end
        2: begin
          logic [7:0] m = 8'($urandom);
          busWrite({2'b00, m, 2'b00}, {24'h0, v});
          mData = (mData & ~(m & mDir)) | (v & m & mDir);
        end
        3: begin
          @(negedge clk); pinIn = v;
          mRaw |= edgeSet(mPin, v);
          mPin = v;
        end
        4: begin
          busWrite(12'h41C, {24'h0, v});
          mRaw &= ~v;
        end
        default: begin
          busWrite(12'hFE0 + 12'(4 * $urandom_range(0, 7)), {24'h0, v});
        end
      endcase
      settle();
      mRaw |= levelSet();
      checkAll(op == 3 ? "R5 R6 R7 R8 pin" : "rand");
    end

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end
endmodule